// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block is one DMA channel that follows a chain of descriptors stored in system memory. It uses a single word-wide memory port with a request/ready handshake. A trigger starts the chain. Each descriptor then tells the sequencer to do one of three things: stop, copy a run of words from a source to a destination, or jump to another descriptor.

When a copy or jump task finishes, the sequencer writes the descriptor's control word back with its count and mode fields zeroed. Software must therefore re-arm a table before it can be used again. A finished task raises a done flag unless the descriptor asks for silence. The flag is cleared by writing 1 to the clear input and is gated onto an interrupt line.

A descriptor address is always the fixed upper half taken from a base input, joined to a link value whose two low bits are forced to zero. A descriptor is four words:
- control at +0: mode in [1:0], suppress in [7], count in [31:16]
- source at +4
- destination at +8
- link in [15:0] of the word at +12

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the channel is not busy, issues no memory request, and the done flag and interrupt are low.
- R2: A trigger taken while idle whose head mode is not 2 (0, 1 or 3) makes no memory access and leaves busy low. It sets the done flag at the next clock edge.
- R3: Every descriptor address equals {base[15:0], link[15:2], 2'b00}. Its words are read at offsets +0 (control), +4 (source), +8 (destination) and +12 (link).
- R4: A memory request holds its address, write enable and write data steady until ready is seen.
- R5: A trigger with head mode 2 while idle raises busy at the next edge. Busy stays high until the chain ends, and a trigger while busy is ignored.
- R6: A descriptor with mode 2 moves no data. Only its control and link words are read, then its link is followed.
- R7: A descriptor with mode 1 copies count words in ascending order with a step of 4, one read then one write per word, then follows its link. A count of 0 copies nothing.
- R8: A fetched control word with mode 0 or 3 ends the chain. No other word of it is read, nothing is written back, and busy falls.
- R9: A finished mode 1 or mode 2 task writes its control word back with bits [31:16] and [1:0] zero and all other bits unchanged.
- R10: A finished task sets the done flag when control bit 7 is 0, and leaves it untouched when bit 7 is 1.
- R11: A pulse on the clear input clears the done flag, but a set in the same cycle wins. The interrupt equals the flag ANDed with the enable input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Start request, one cycle |
| head_mode_i | input | 2 | Mode of the channel head; 2 starts a chain |
| head_link_i | input | 16 | Link to the first descriptor |
| base_hi_i | input | 16 | Upper half of all descriptor addresses, sampled at trigger |
| done_clr_i | input | 1 | Write-1-to-clear for the done flag |
| irq_en_i | input | 1 | Interrupt enable |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Chain in progress |
| done_o | output | 1 | Task-done flag |
| irq_o | output | 1 | Interrupt |

## Verification
The assertions assume the memory returns valid read data in the cycle it raises ready. They also assume ready eventually arrives and that descriptors hold word-aligned source and destination addresses. They do not constrain the base or head link inputs outside the trigger cycle, because the block samples those inputs only at the trigger.

The bench memory model answers combinationally and paces ready in three patterns: always, every other cycle, and one in three. It places every descriptor and data word inside one 4 KB window under a single base. The model counts any access outside that window or off word alignment, so an address-forming error shows up at the ports.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 16;
    localparam int CNT_LSB = 16;
    localparam int SUP_BIT = 7;

    localparam logic [1:0] MODE_STOP  = 2'd0;
    localparam logic [1:0] MODE_BASIC = 2'd1;
    localparam logic [1:0] MODE_LINK  = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_RD,
        S_WR,
        S_WB
    } seq_st_e;
endpackage

// File: rtl/dma_link_addr.sv
module dma_link_addr #(
    parameter int AW = 32
) (
    input  logic [AW/2-1:0] base_i,
    input  logic [AW/2-1:0] link_i,
    output logic [AW-1:0]   addr_o
);
    localparam logic [AW-1:0] LOW_MASK = AW'(3);

    // upper half from the base, lower half from the link, word aligned
    assign addr_o = {base_i, link_i} & ~LOW_MASK;
endmodule

// File: rtl/dma_done_flag.sv
module dma_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;

    // R10: the flag only rises after a task completion
    a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_i));

    // R11: a clear without a concurrent set drops the flag
    a_r11_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [1:0]        head_mode_i,
    input  logic [AW/2-1:0]   head_link_i,
    input  logic [AW/2-1:0]   base_hi_i,
    input  logic              done_clr_i,
    input  logic              irq_en_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_o
);
    localparam int HW = AW / 2;
    localparam logic [AW-1:0] STEP = AW'(4);

    typedef struct packed {
        seq_st_e           st;
        logic [1:0]        widx;
        logic [AW-1:0]     dsc;
        logic [WORD_W-1:0] ctl;
        logic [AW-1:0]     src;
        logic [AW-1:0]     dst;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  left;
        logic [HW-1:0]     base;
        logic [HW-1:0]     link;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic          set_done;
    logic [HW-1:0] sel_base, sel_link;
    logic [AW-1:0] nxt_addr;
    logic [1:0]    ctl_mode;
    logic [WORD_W-1:0] wb_word;

    // in idle the head inputs pick the first entry, afterwards the stored link
    assign sel_base = (r_q.st == S_IDLE) ? base_hi_i   : r_q.base;
    assign sel_link = (r_q.st == S_IDLE) ? head_link_i : r_q.link;

    dma_link_addr #(.AW(AW)) u_link_addr (
        .base_i (sel_base),
        .link_i (sel_link),
        .addr_o (nxt_addr)
    );

    assign ctl_mode = r_q.ctl[1:0];

    always_comb begin
        wb_word = r_q.ctl;
        wb_word[CNT_LSB +: CNT_W] = '0;
        wb_word[1:0] = '0;
    end

    always_comb begin
        r_d         = r_q;
        set_done    = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (r_q.st)
            S_IDLE: begin
                if (trig_i) begin
                    if (head_mode_i == MODE_LINK) begin
                        r_d.base = base_hi_i;
                        r_d.dsc  = nxt_addr;
                        r_d.widx = 2'd0;
                        r_d.st   = S_FETCH;
                    end else begin
                        set_done = 1'b1;
                    end
                end
            end
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.dsc + {{(AW-4){1'b0}}, r_q.widx, 2'b00};
                if (mem_rdy_i) begin
                    unique case (r_q.widx)
                        2'd0: begin
                            r_d.ctl = mem_rdata_i;
                            if (mem_rdata_i[1:0] == MODE_BASIC)     r_d.widx = 2'd1;
                            else if (mem_rdata_i[1:0] == MODE_LINK) r_d.widx = 2'd3;
                            else                                    r_d.st   = S_IDLE;
                        end
                        2'd1: begin
                            r_d.src  = mem_rdata_i[AW-1:0];
                            r_d.widx = 2'd2;
                        end
                        2'd2: begin
                            r_d.dst  = mem_rdata_i[AW-1:0];
                            r_d.widx = 2'd3;
                        end
                        default: begin
                            r_d.link = mem_rdata_i[HW-1:0];
                            r_d.left = r_q.ctl[CNT_LSB +: CNT_W];
                            if (ctl_mode == MODE_BASIC && r_q.ctl[CNT_LSB +: CNT_W] != '0)
                                r_d.st = S_RD;
                            else
                                r_d.st = S_WB;
                        end
                    endcase
                end
            end
            S_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.src;
                if (mem_rdy_i) begin
                    r_d.word = mem_rdata_i;
                    r_d.st   = S_WR;
                end
            end
            S_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.dst;
                mem_wdata_o = r_q.word;
                if (mem_rdy_i) begin
                    r_d.src  = r_q.src + STEP;
                    r_d.dst  = r_q.dst + STEP;
                    r_d.left = r_q.left - CNT_W'(1);
                    r_d.st   = (r_q.left == CNT_W'(1)) ? S_WB : S_RD;
                end
            end
            S_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.dsc;
                mem_wdata_o = wb_word;
                if (mem_rdy_i) begin
                    set_done = ~r_q.ctl[SUP_BIT];
                    r_d.dsc  = nxt_addr;
                    r_d.widx = 2'd0;
                    r_d.st   = S_FETCH;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.st != S_IDLE);

    dma_done_flag u_done_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_done),
        .clr_i  (done_clr_i),
        .en_i   (irq_en_i),
        .flag_o (done_o),
        .irq_o  (irq_o)
    );

    // R4: a stalled access keeps every field of the request
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)
            && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R5: busy only starts from an accepted trigger
    a_r5_busy_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(trig_i));

    // R6: data reads only happen for copy descriptors
    a_r6_copy_only_basic: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RD) |-> (ctl_mode == MODE_BASIC));

    // R8: an idle channel never touches memory
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !mem_req_o);
endmodule

// File: tb/dma_chain_seq_bench.sv
module dma_chain_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  head_mode = 2'd0;
    logic [15:0] head_link = 16'd0;
    logic [15:0] base_hi = 16'h2000;
    logic        clr = 1'b0;
    logic        en = 1'b1;
    logic        mem_req, mem_we, mem_rdy;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, irq;

    logic [31:0] mem [0:1023];
    int unsigned acc_cnt = 0;
    int unsigned bad_addr = 0;
    int unsigned stall_ctr = 0;
    int          stall_mode = 0;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    dma_chain_seq u_dma_chain_seq (
        .clk (clk), .rst_n (rst_n), .trig_i (trig), .head_mode_i (head_mode),
        .head_link_i (head_link), .base_hi_i (base_hi), .done_clr_i (clr),
        .irq_en_i (en), .mem_req_o (mem_req), .mem_we_o (mem_we),
        .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
        .mem_rdy_i (mem_rdy), .busy_o (busy), .done_o (done), .irq_o (irq)
    );

    assign mem_rdata = mem[mem_addr[11:2]];

    always @(negedge clk) begin
        stall_ctr = stall_ctr + 1;
        case (stall_mode)
            0: mem_rdy = 1'b1;
            1: mem_rdy = stall_ctr[0];
            default: mem_rdy = (stall_ctr % 3 == 2);
        endcase
    end

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_rdy) begin
            acc_cnt = acc_cnt + 1;
            if (mem_addr[31:16] != 16'h2000 || mem_addr[15:12] != 4'h0 || mem_addr[1:0] != 2'b00)
                bad_addr = bad_addr + 1;
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_ctl(input logic [15:0] cnt, input logic sup, input logic [1:0] mode);
        return {cnt, 8'h3C, sup, 5'b10100, mode};
    endfunction

    task automatic put_dsc(input logic [15:0] at, input logic [31:0] ctl, input logic [31:0] s,
                           input logic [31:0] d, input logic [15:0] nl);
        mem[at[11:2]]     = ctl;
        mem[at[11:2] + 1] = s;
        mem[at[11:2] + 2] = d;
        mem[at[11:2] + 3] = {16'hBEEF, nl};
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic kick(input logic [1:0] m, input logic [15:0] l);
        @(negedge clk); trig = 1'b1; head_mode = m; head_link = l;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic fill_data(input int run);
        for (int i = 0; i < 8; i++) begin
            mem[256 + i] = {8'(run), 8'(i), 16'h5A5A};
            mem[512 + i] = 32'hDEAD_0000 | i;
            mem[768 + i] = 32'hC0DE_0000 | i;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog act=%h exp=%h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int run = 0;
        int unsigned snap;
        logic [31:0] c0, c1, c2, sv;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 req", {31'd0, mem_req}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R2: non-chain head modes
        for (int hm = 0; hm < 4; hm++) begin
            if (hm == 2) continue;
            pulse_clr();
            snap = acc_cnt;
            kick(2'(hm), 16'h0100);
            chk("R2 busy low", {31'd0, busy}, 32'd0);
            chk("R2 done set", {31'd0, irq}, 32'd1);
            repeat (3) @(negedge clk);
            chk("R2 no access", acc_cnt - snap, 32'd0);
        end

        // R11: enable gating and set beating clear
        en = 1'b0;
        @(negedge clk);
        chk("R11 irq gated", {31'd0, irq}, 32'd0);
        chk("R11 flag kept", {31'd0, done}, 32'd1);
        en = 1'b1;
        pulse_clr();
        chk("R11 cleared", {31'd0, done}, 32'd0);
        @(negedge clk); trig = 1'b1; head_mode = 2'd0; clr = 1'b1;
        @(negedge clk); trig = 1'b0; clr = 1'b0;
        chk("R11 set wins", {31'd0, done}, 32'd1);

        // R3 R6 R7 R9 R10 sweep
        for (int sm = 0; sm < 3; sm++) begin
            for (int n = 0; n < 5; n++) begin
                for (int s0 = 0; s0 < 2; s0++) begin
                    for (int s1 = 0; s1 < 2; s1++) begin
                        run++;
                        stall_mode = sm;
                        pulse_clr();
                        fill_data(run);
                        c0 = mk_ctl(16'h0007, s0[0], 2'd2);
                        c1 = mk_ctl(16'(n), s1[0], 2'd1);
                        c2 = mk_ctl(16'h0009, 1'b0, 2'd0);
                        put_dsc(16'h0100, c0, 32'h1111_1111, 32'h2222_2222, 16'h0113);
                        put_dsc(16'h0110, c1, 32'h2000_0400, 32'h2000_0800, 16'h0120);
                        put_dsc(16'h0120, c2, 32'h2000_0400, 32'h2000_0800, 16'h0100);
                        snap = acc_cnt;
                        kick(2'd2, 16'h0102);
                        chk("R5 busy up", {31'd0, busy}, 32'd1);
                        wait_idle();
                        chk("R6 R7 access count", acc_cnt - snap, 32'(9 + 2 * n));
                        for (int i = 0; i < 8; i++) begin
                            sv = (i < n) ? mem[256 + i] : (32'hDEAD_0000 | i);
                            chk("R7 dst word", mem[512 + i], sv);
                        end
                        chk("R9 jump wb", mem[64], c0 & 32'h0000_FFFC);
                        chk("R9 copy wb", mem[68], c1 & 32'h0000_FFFC);
                        chk("R8 end untouched", mem[72], c2);
                        chk("R6 no data", mem[65], 32'h1111_1111);
                        chk("R10 flag", {31'd0, irq}, {31'd0, ~(s0[0] & s1[0])});
                    end
                end
            end
        end
        chk("R3 address window", bad_addr, 32'd0);

        // R5: trigger while busy is ignored
        stall_mode = 1;
        pulse_clr();
        fill_data(99);
        c1 = mk_ctl(16'd6, 1'b0, 2'd1);
        put_dsc(16'h0100, mk_ctl(16'd0, 1'b0, 2'd2), 32'h0, 32'h0, 16'h0110);
        put_dsc(16'h0110, c1, 32'h2000_0400, 32'h2000_0800, 16'h0120);
        put_dsc(16'h0120, mk_ctl(16'd0, 1'b0, 2'd0), 32'h0, 32'h0, 16'h0);
        c2 = mk_ctl(16'd2, 1'b0, 2'd1);
        put_dsc(16'h0180, c2, 32'h2000_0400, 32'h2000_0C00, 16'h0120);
        snap = acc_cnt;
        kick(2'd2, 16'h0100);
        repeat (6) @(negedge clk);
        kick(2'd2, 16'h0180);
        wait_idle();
        chk("R5 second ignored ctl", mem[96], c2);
        chk("R5 second ignored dst", mem[768], 32'hC0DE_0000);
        chk("R5 access count", acc_cnt - snap, 32'd21);
        chk("R5 busy fell", {31'd0, busy}, 32'd0);

        // R8: fetched reserved mode ends the chain
        stall_mode = 2;
        pulse_clr();
        c2 = mk_ctl(16'd3, 1'b0, 2'd3);
        put_dsc(16'h0140, c2, 32'h2000_0400, 32'h2000_0800, 16'h0100);
        snap = acc_cnt;
        kick(2'd2, 16'h0140);
        wait_idle();
        chk("R8 one access", acc_cnt - snap, 32'd1);
        chk("R8 no writeback", mem[80], c2);
        chk("R8 no flag", {31'd0, done}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule